// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between the serial slave engine of a two-wire memory and its storage array. Once the engine has received a word address it opens a write session. The engine then forwards each received data byte, and the block answers each byte with an acknowledge decision. Bytes go into a page-sized buffer. The low offset bits of the address advance after every byte and wrap inside the page, while the page bits stay where the session put them.

A STOP that ends a session holding at least one accepted byte commits the buffer. The block issues one array write per filled position, in a single burst ordered by ascending offset, and then holds a busy flag for a timed write cycle measured in system clocks. While busy is high, the block starts no new session and refuses every byte, so a host that polls sees refusals until the cycle ends.

A protect input is latched when the engine marks the clock edge that comes just before the first data byte. If the latched value is high, every byte of that session is refused and nothing is committed.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy, mem_we and ack_vld are all 0.
- R2: Every byte_vld pulse is answered by exactly one ack_vld pulse in the next cycle. ack is 1 only when a session is open, the session is not protected, and the block is not busy. A byte that arrives with no session open gets ack 0.
- R3: wr_begin sets the page to wr_addr[ADDR_W-1:4] and the offset to wr_addr[3:0]. Each accepted byte is stored at the current offset, and the offset then increments modulo 16. The page bits never change within a session.
- R4: If more than 16 bytes are accepted in one session, a later byte overwrites the byte stored earlier at the same offset. Only the last value at each offset is committed.
- R5: A stop_evt with at least one accepted byte starts a burst of mem_we pulses, one for each filled offset, in ascending offset order. Each pulse carries mem_addr = {page, offset} and that offset's last data. Offsets that received no byte are not written.
- R6: After a committing stop_evt, busy is high for exactly PAGE_BYTES + WR_CYCLES cycles, starting the cycle after the stop. While busy is high, wr_begin is ignored and every byte gets ack 0.
- R7: wp_pin is latched at a wp_sample pulse that arrives before the first byte of a session. If the latched value is 1, all bytes of that session get ack 0 and the stop that follows writes nothing and leaves busy at 0.
- R8: A start_evt that arrives before stop discards the open session without writing. A stop_evt that arrives when no byte has been accepted writes nothing and leaves busy at 0.
- R9: A change on wp_pin away from the wp_sample pulse has no effect on acknowledge decisions or on the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_begin | input | 1 | Pulse: the word address has been received, so a session opens |
| wr_addr | input | ADDR_W | Start address of the session |
| byte_vld | input | 1 | Pulse: a data byte has been received |
| byte_data | input | 8 | Received data byte |
| wp_sample | input | 1 | Pulse marking the edge at which the protect pin is strobed |
| wp_pin | input | 1 | Hardware protect level |
| start_evt | input | 1 | Pulse: a START condition was detected |
| stop_evt | input | 1 | Pulse: a STOP condition was detected |
| ack_vld | output | 1 | Acknowledge decision is valid this cycle |
| ack | output | 1 | 1 = acknowledge the byte, 0 = refuse it |
| busy | output | 1 | Commit burst or timed write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume that every event input is a pulse one cycle wide and that no two event pulses arrive in the same cycle. They also assume that byte_vld stays low during the reset cycle, so the check that ties each ack_vld to a preceding byte is valid from the first cycle. The bench drives each event as an isolated pulse between falling clock edges and leaves at least one idle cycle between pulses, so no stimulus falls outside these assumptions.

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              wp_sample,
  input  logic              wp_pin,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              ack_vld,
  output logic              ack,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_COMMIT, S_WAIT} st_t;

  st_t                   st;
  logic [PG_W-1:0]       page;
  logic [OFS_W-1:0]      ptr, idx;
  logic [PAGE_BYTES-1:0] filled;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic                  prot;
  logic [TMR_W-1:0]      tmr;

  wire accept = (st == S_FILL) && !prot && byte_vld;

  assign busy      = (st == S_COMMIT) || (st == S_WAIT);
  assign mem_we    = (st == S_COMMIT) && filled[idx];
  assign mem_addr  = {page, idx};
  assign mem_wdata = pbuf[idx];

  always_ff @(posedge clk) begin
    if (accept) pbuf[ptr] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack_vld <= byte_vld;
      ack     <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      page   <= '0;
      ptr    <= '0;
      idx    <= '0;
      filled <= '0;
      prot   <= 1'b0;
      tmr    <= '0;
    end else begin
      case (st)
        S_IDLE, S_FILL: begin
          if (start_evt) begin
            st     <= S_IDLE;
            filled <= '0;
          end else if (wr_begin) begin
            st     <= S_FILL;
            page   <= wr_addr[ADDR_W-1:OFS_W];
            ptr    <= wr_addr[OFS_W-1:0];
            filled <= '0;
            prot   <= 1'b0;
          end else if (st == S_FILL) begin
            if (wp_sample && filled == '0) prot <= wp_pin;
            if (accept) begin
              filled[ptr] <= 1'b1;
              ptr         <= ptr + OFS_W'(1);
            end
            if (stop_evt) begin
              if (filled != '0 && !prot) begin
                st  <= S_COMMIT;
                idx <= '0;
              end else begin
                st     <= S_IDLE;
                filled <= '0;
              end
            end
          end
        end
        S_COMMIT: begin
          idx <= idx + OFS_W'(1);
          if (idx == OFS_W'(PAGE_BYTES - 1)) begin
            st  <= S_WAIT;
            tmr <= '0;
          end
        end
        S_WAIT: begin
          tmr <= tmr + TMR_W'(1);
          if (tmr == TMR_W'(WR_CYCLES - 1)) begin
            st     <= S_IDLE;
            filled <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module page_write_ctrl_chk #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              stop_evt,
  input logic              ack_vld,
  input logic              ack,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> ack_vld); // R2
  AST_ACK_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(byte_vld)); // R2
  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && busy) |=> !ack); // R6
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt)); // R6
  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])); // R3
  AST_OFS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      mem_addr[OFS_W-1:0] > $past(mem_addr[OFS_W-1:0])); // R5
endmodule

bind page_write_ctrl page_write_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .stop_evt(stop_evt),
  .ack_vld(ack_vld), .ack(ack), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/test_page_write_ctrl.sv
`timescale 1ns/1ps
module test_page_write_ctrl;
  localparam int AW = 11;
  localparam int PB = 16;
  localparam int WC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_begin = 0, byte_vld = 0, wp_sample = 0, wp_pin = 0, start_evt = 0, stop_evt = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] byte_data = '0;
  logic ack_vld, ack, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_run = 0, n_fail = 0;
  logic        ackq [$];
  logic [18:0] wq [$];

  logic [AW-5:0] m_page;
  logic [3:0]    m_ptr;
  logic          m_mask [PB];
  logic [7:0]    m_data [PB];

  always #10 clk = ~clk;

  page_write_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WC)) i_page_write_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .wp_sample(wp_sample),
    .wp_pin(wp_pin), .start_evt(start_evt), .stop_evt(stop_evt),
    .ack_vld(ack_vld), .ack(ack), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (ack_vld) begin
      if (ackq.size() == 0) check(0, "R2 unexpected ack_vld", 1, 0);
      else begin
        logic e;
        e = ackq.pop_front();
        check(ack == e, "R2/R6/R7 ack decision", int'(ack), int'(e));
      end
    end
    if (mem_we) begin
      if (wq.size() == 0) check(0, "R5/R8 unexpected array write", int'({mem_addr, mem_wdata}), 0);
      else begin
        logic [18:0] e;
        e = wq.pop_front();
        check({mem_addr, mem_wdata} == e, "R3/R4/R5 array write", int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  task automatic begin_wr(input logic [AW-1:0] a);
    @(negedge clk); wr_begin = 1; wr_addr = a;
    @(negedge clk); wr_begin = 0;
    m_page = a[AW-1:4]; m_ptr = a[3:0];
    for (int i = 0; i < PB; i++) m_mask[i] = 0;
  endtask

  task automatic strobe_wp(input logic lvl);
    @(negedge clk); wp_pin = lvl; wp_sample = 1;
    @(negedge clk); wp_sample = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic exp_ack);
    ackq.push_back(exp_ack);
    if (exp_ack) begin
      m_mask[m_ptr] = 1; m_data[m_ptr] = d; m_ptr = m_ptr + 4'd1;
    end
    @(negedge clk); byte_vld = 1; byte_data = d;
    @(negedge clk); byte_vld = 0;
  endtask

  task automatic send_start();
    @(negedge clk); start_evt = 1;
    @(negedge clk); start_evt = 0;
  endtask

  task automatic send_stop(input bit commit, input bit wait_idle);
    int cnt;
    if (commit)
      for (int i = 0; i < PB; i++)
        if (m_mask[i]) wq.push_back({m_page, 4'(i), m_data[i]});
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
    if (!commit) check(busy == 0, "R7/R8 busy stays low without commit", int'(busy), 0);
    else if (wait_idle) begin
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); end
      check(cnt == PB + WC, "R6 busy length", cnt, PB + WC);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check(wq.size() == 0, "R5 missing array writes", wq.size(), 0);
    check(ackq.size() == 0, "R2 missing ack_vld", ackq.size(), 0);
  endtask

  initial begin
    repeat (1000 * PB + 20 * WC) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && mem_we == 0 && ack_vld == 0, "R1 reset outputs",
          int'({busy, mem_we, ack_vld}), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: byte outside any session is refused
    send_byte(8'h11, 0);
    drain();

    // R5 R6: single byte commit
    begin_wr(11'h123); strobe_wp(0);
    send_byte(8'h5A, 1);
    send_stop(1, 1);
    drain();

    // R3: offset wraps inside the page
    begin_wr(11'h07D); strobe_wp(0);
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i), 1);
    send_stop(1, 1);
    drain();

    // R4: 18 bytes overwrite offsets 0 and 1
    begin_wr(11'h200); strobe_wp(0);
    for (int i = 0; i < 18; i++) send_byte(8'(i * 7 + 3), 1);
    send_stop(1, 1);
    drain();

    // R7: protected session refused
    begin_wr(11'h345); strobe_wp(1);
    send_byte(8'hC3, 0);
    send_byte(8'hC4, 0);
    wp_pin = 0;
    send_stop(0, 0);
    drain();

    // R9: protect pin raised after the strobe is ignored
    begin_wr(11'h3F0); strobe_wp(0);
    wp_pin = 1;
    send_byte(8'h77, 1);
    send_byte(8'h78, 1);
    send_stop(1, 1);
    wp_pin = 0;
    drain();

    // R8: START discards an open session
    begin_wr(11'h010); strobe_wp(0);
    send_byte(8'h99, 1);
    send_start();
    for (int i = 0; i < PB; i++) m_mask[i] = 0;
    send_stop(0, 0);
    drain();

    // R8: STOP with no data
    begin_wr(11'h020); strobe_wp(0);
    send_stop(0, 0);
    drain();

    // R6: polling during the write cycle is refused
    begin_wr(11'h456); strobe_wp(0);
    send_byte(8'hE1, 1);
    send_stop(1, 0);
    check(busy == 1, "R6 busy after commit", int'(busy), 1);
    begin_wr(11'h500);
    send_byte(8'hE2, 0);
    while (busy) @(negedge clk);
    for (int i = 0; i < PB; i++) m_mask[i] = 0;
    send_byte(8'hE3, 0);
    send_stop(0, 0);
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule